// File: doc/BRIEF.md
# ISDN B-Channel Time-Slot Port

This block moves one 8-bit sample per frame into and out of a 2B+D style serial bus. It takes the bus's frame sync, data clock and serial input, and returns a serial output with a separate output enable, so the pad can tri-state it. Exactly one of the two B-channel slots is used in each frame. A channel-select input picks which one, and a strap input picks which of two slot timings applies. In the half-rate format, each bit takes two data-clock cycles. In the single-rate format, the second channel begins ten clocks after the first.

All bus inputs come in asynchronously. They are resampled into the system clock through a parameterised synchroniser chain, and the edges of the data clock are found in that domain. A frame starts on the first data-clock rising edge at which sync is seen high. From that edge, a saturating edge counter places every transmit bit, every receive sample and the release of the output enable. The byte to send is taken from a parallel input. The byte received is shown on a parallel output, together with a one-cycle strobe.

Top module: `isdn_slot_port`

## Requirements
- R1: While reset is high and after reset is released, sdo_oe and rx_valid are low and rx_byte is zero, and no format is accepted yet.
- R2: fmt_strap is sampled at every frame start (0 = half-rate format, 1 = single-rate format). A level seen at STABLE_FRAMES (default 2) consecutive frame starts becomes the accepted format, starting with the frame whose start completes the run. Until a format has been accepted, sdo_oe stays low and nothing is received.
- R3: chan_sel is sampled at each frame start and holds for the whole frame. 0 selects the first B slot and 1 selects the second, for both directions.
- R4: A frame starts at the data-clock rising edge where fsync is high, provided fsync was low at the previous rising edge. That edge has rising index 0. The falling edge that follows rising index j has falling index j.
- R5: In the half-rate format, the slot base is 0 (first slot) or 16 (second slot). Bit k (k = 0..7, MSB first) is driven from rising index base+2k. sdo_oe rises at rising index base and falls at falling index base+15.
- R6: In the half-rate format, received bit k is sampled at rising index base+2k+1.
- R7: In the single-rate format, the slot base is 0 or 10. Bit k is driven from rising index base+1+k. sdo_oe rises at rising index base+1 and falls at falling index base+8.
- R8: In the single-rate format, received bit k is sampled at falling index base+1+k.
- R9: tx_byte is captured on the edge that drives the first bit. Later changes to tx_byte during that frame have no effect on sdo.
- R10: When the eighth bit is sampled, rx_byte takes the eight bits (the first one as the MSB) and rx_valid is high for one system clock. sdi outside the selected slot has no effect.
- R11: sdo changes only right after a detected data-clock rising edge. sdo_oe rises only after a rising edge and falls only after a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the data clock |
| rst | input | 1 | Synchronous active-high reset |
| dclk | input | 1 | Bus data clock |
| fsync | input | 1 | Bus frame sync |
| sdi | input | 1 | Serial receive data |
| fmt_strap | input | 1 | Format strap: 0 half-rate, 1 single-rate |
| chan_sel | input | 1 | B-slot select: 0 first, 1 second |
| tx_byte | input | 8 | Sample to transmit |
| sdo | output | 1 | Serial transmit data |
| sdo_oe | output | 1 | Output enable for sdo |
| rx_byte | output | 8 | Last received sample |
| rx_valid | output | 1 | One-cycle strobe when rx_byte updates |

## Verification
The bench sweeps both formats and both slots, and inside each frame it drives filler bits on sdi outside the chosen slot. A design that samples in the wrong slot, or off by one edge, shows a corrupted rx_byte. If the second-slot base were 16 in the single-rate format, or the half-rate window were counted per edge and not per pair of edges, the enable window and bit check would fail. tx_byte is changed just after the slot opens, which exposes a design that reads the byte live instead of capturing it. The strap is also changed and toggled every frame: a design that switches format on a single sample, or applies the new format one frame late, drives the wrong window in the frame the model predicts.

// File: rtl/isdn_slot_pkg.sv
package isdn_slot_pkg;

    localparam int SAMPLE_W     = 8;
    localparam int IDX_W        = $clog2(SAMPLE_W);
    localparam int HALF_SLOT    = 2 * SAMPLE_W;
    localparam int HALF_B2_BASE = 16;
    localparam int FULL_B2_BASE = 10;

    typedef enum logic {
        FMT_HALF = 1'b0,
        FMT_FULL = 1'b1
    } bus_fmt_e;

    typedef enum logic {
        SLOT_FIRST  = 1'b0,
        SLOT_SECOND = 1'b1
    } slot_e;

    typedef struct packed {
        logic             drive;
        logic             sample;
        logic             rel_oe;
        logic [IDX_W-1:0] idx;
    } edge_act_t;

    function automatic int slot_base(bus_fmt_e f, slot_e s);
        if (s == SLOT_FIRST) return 0;
        return (f == FMT_HALF) ? HALF_B2_BASE : FULL_B2_BASE;
    endfunction

    // Action on a data-clock rising edge whose index is cnt
    function automatic edge_act_t on_rise(bus_fmt_e f, slot_e s, int cnt);
        edge_act_t a;
        int rel;
        a = '0;
        if (f == FMT_HALF) begin
            rel = cnt - slot_base(f, s);
            if (rel >= 0 && rel < HALF_SLOT) begin
                a.idx = IDX_W'(rel / 2);
                if (rel % 2 == 0) a.drive  = 1'b1;
                else              a.sample = 1'b1;
            end
        end else begin
            rel = cnt - slot_base(f, s) - 1;
            if (rel >= 0 && rel < SAMPLE_W) begin
                a.idx   = IDX_W'(rel);
                a.drive = 1'b1;
            end
        end
        return a;
    endfunction

    // Action on the falling edge that follows rising index cnt
    function automatic edge_act_t on_fall(bus_fmt_e f, slot_e s, int cnt);
        edge_act_t a;
        int rel;
        a = '0;
        if (f == FMT_HALF) begin
            rel = cnt - slot_base(f, s);
            if (rel == HALF_SLOT - 1) a.rel_oe = 1'b1;
        end else begin
            rel = cnt - slot_base(f, s) - 1;
            if (rel >= 0 && rel < SAMPLE_W) begin
                a.idx    = IDX_W'(rel);
                a.sample = 1'b1;
                a.rel_oe = (rel == SAMPLE_W - 1);
            end
        end
        return a;
    endfunction

endpackage

// File: rtl/isdn_slot_sync.sv
module isdn_slot_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic dclk,
    input  logic fsync,
    input  logic sdi,
    output logic dclk_rise,
    output logic dclk_fall,
    output logic frame_start,
    output logic sdi_s
);
    localparam int LANES = 3;

    logic [STAGES-1:0][LANES-1:0] stg;
    logic dclk_last;
    logic fs_at_rise;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= '0;
                    else     stg[i] <= {dclk, fsync, sdi};
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= '0;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign dclk_rise   = stg[STAGES-1][2] & ~dclk_last;
    assign dclk_fall   = ~stg[STAGES-1][2] & dclk_last;
    assign frame_start = dclk_rise & stg[STAGES-1][1] & ~fs_at_rise;
    assign sdi_s       = stg[STAGES-1][0];

    always_ff @(posedge clk) begin
        if (rst) begin
            dclk_last  <= 1'b0;
            fs_at_rise <= 1'b0;
        end else begin
            dclk_last <= stg[STAGES-1][2];
            if (dclk_rise) fs_at_rise <= stg[STAGES-1][1];
        end
    end
endmodule

// File: rtl/isdn_slot_modeq.sv
module isdn_slot_modeq
    import isdn_slot_pkg::*;
#(
    parameter int STABLE_FRAMES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     frame_start,
    input  logic     strap,
    output logic     mode_ok,
    output bus_fmt_e fmt,
    output logic     eff_ok,
    output bus_fmt_e eff_fmt
);
    localparam int RUN_W = $clog2(STABLE_FRAMES + 1);
    localparam logic [RUN_W-1:0] RUN_DONE = RUN_W'(STABLE_FRAMES);

    logic             cand_q, cand_n;
    logic [RUN_W-1:0] run_q, run_n;

    always_comb begin
        cand_n  = cand_q;
        run_n   = run_q;
        eff_ok  = mode_ok;
        eff_fmt = fmt;
        if (frame_start) begin
            cand_n = strap;
            if (run_q != '0 && strap == cand_q)
                run_n = (run_q == RUN_DONE) ? run_q : run_q + RUN_W'(1);
            else
                run_n = RUN_W'(1);
            if (run_n == RUN_DONE) begin
                eff_ok  = 1'b1;
                eff_fmt = bus_fmt_e'(strap);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q  <= 1'b0;
            run_q   <= '0;
            mode_ok <= 1'b0;
            fmt     <= FMT_HALF;
        end else begin
            cand_q  <= cand_n;
            run_q   <= run_n;
            mode_ok <= eff_ok;
            fmt     <= eff_fmt;
        end
    end
endmodule

// File: rtl/isdn_slot_engine.sv
module isdn_slot_engine
    import isdn_slot_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                dclk_rise,
    input  logic                dclk_fall,
    input  logic                frame_start,
    input  logic                sdi_s,
    input  logic                chan_sel,
    input  logic                mode_ok,
    input  bus_fmt_e            fmt,
    input  logic                eff_ok,
    input  bus_fmt_e            eff_fmt,
    input  logic [SAMPLE_W-1:0] tx_byte,
    output logic                sdo,
    output logic                sdo_oe,
    output logic [SAMPLE_W-1:0] rx_byte,
    output logic                rx_valid
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SAMPLE_W - 1);

    logic [CNT_W-1:0]    cnt_q, cnt_n;
    slot_e               ch_q, eff_ch;
    logic [SAMPLE_W-1:0] hold_q, shift_q;
    edge_act_t           ra, fa;

    always_comb begin
        if (frame_start)          cnt_n = '0;
        else if (cnt_q == CNT_MAX) cnt_n = cnt_q;
        else                      cnt_n = cnt_q + CNT_W'(1);
        eff_ch = frame_start ? slot_e'(chan_sel) : ch_q;
        ra     = on_rise(eff_fmt, eff_ch, int'(cnt_n));
        fa     = on_fall(fmt, ch_q, int'(cnt_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= CNT_MAX;
            ch_q     <= SLOT_FIRST;
            hold_q   <= '0;
            shift_q  <= '0;
            sdo      <= 1'b0;
            sdo_oe   <= 1'b0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (dclk_rise) begin
                cnt_q <= cnt_n;
                ch_q  <= eff_ch;
                if (eff_ok && ra.drive) begin
                    if (ra.idx == '0) begin
                        hold_q <= tx_byte;
                        sdo    <= tx_byte[SAMPLE_W-1];
                        sdo_oe <= 1'b1;
                    end else begin
                        sdo <= hold_q[LAST_IDX - ra.idx];
                    end
                end
                if (eff_ok && ra.sample) begin
                    shift_q <= {shift_q[SAMPLE_W-2:0], sdi_s};
                    if (ra.idx == LAST_IDX) begin
                        rx_byte  <= {shift_q[SAMPLE_W-2:0], sdi_s};
                        rx_valid <= 1'b1;
                    end
                end
            end
            if (dclk_fall && mode_ok) begin
                if (fa.sample) begin
                    shift_q <= {shift_q[SAMPLE_W-2:0], sdi_s};
                    if (fa.idx == LAST_IDX) begin
                        rx_byte  <= {shift_q[SAMPLE_W-2:0], sdi_s};
                        rx_valid <= 1'b1;
                    end
                end
                if (fa.rel_oe) begin
                    sdo_oe <= 1'b0;
                    sdo    <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/isdn_slot_port.sv
module isdn_slot_port
    import isdn_slot_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_FRAMES = 2,
    parameter int CNT_W         = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                dclk,
    input  logic                fsync,
    input  logic                sdi,
    input  logic                fmt_strap,
    input  logic                chan_sel,
    input  logic [SAMPLE_W-1:0] tx_byte,
    output logic                sdo,
    output logic                sdo_oe,
    output logic [SAMPLE_W-1:0] rx_byte,
    output logic                rx_valid
);
    logic     dclk_rise, dclk_fall, frame_start, sdi_s;
    logic     mode_ok, eff_ok;
    bus_fmt_e fmt, eff_fmt;

    isdn_slot_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .dclk(dclk), .fsync(fsync), .sdi(sdi),
        .dclk_rise(dclk_rise), .dclk_fall(dclk_fall),
        .frame_start(frame_start), .sdi_s(sdi_s)
    );

    isdn_slot_modeq #(.STABLE_FRAMES(STABLE_FRAMES)) modeq_i (
        .clk(clk), .rst(rst), .frame_start(frame_start), .strap(fmt_strap),
        .mode_ok(mode_ok), .fmt(fmt), .eff_ok(eff_ok), .eff_fmt(eff_fmt)
    );

    isdn_slot_engine #(.CNT_W(CNT_W)) engine_i (
        .clk(clk), .rst(rst), .dclk_rise(dclk_rise), .dclk_fall(dclk_fall),
        .frame_start(frame_start), .sdi_s(sdi_s), .chan_sel(chan_sel),
        .mode_ok(mode_ok), .fmt(fmt), .eff_ok(eff_ok), .eff_fmt(eff_fmt),
        .tx_byte(tx_byte), .sdo(sdo), .sdo_oe(sdo_oe),
        .rx_byte(rx_byte), .rx_valid(rx_valid)
    );
endmodule

// File: rtl/isdn_slot_port_chk.sv
module isdn_slot_port_chk (
    input logic clk,
    input logic rst,
    input logic rise,
    input logic fall,
    input logic mode_ok,
    input logic sdo,
    input logic sdo_oe,
    input logic rx_valid
);
    // R2: no drive before a format is accepted
    a_r2_quiet_until_mode: assert property (@(posedge clk) disable iff (rst)
        !mode_ok |-> !sdo_oe);

    // R11: data moves only right after a rising strobe
    a_r11_sdo_on_rise: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe && $past(sdo_oe) && !$past(rise)) |-> $stable(sdo));

    // R11: enable opens after a rising strobe
    a_r11_oe_up_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_oe) |-> $past(rise));

    // R11: enable closes after a falling strobe
    a_r11_oe_down_on_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(sdo_oe) |-> $past(fall));

    // R10: receive strobe lasts one cycle
    a_r10_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
endmodule

bind isdn_slot_port isdn_slot_port_chk chk_i (
    .clk(clk), .rst(rst), .rise(dclk_rise), .fall(dclk_fall),
    .mode_ok(mode_ok), .sdo(sdo), .sdo_oe(sdo_oe), .rx_valid(rx_valid)
);

// File: tb/isdn_slot_port_tb_top.sv
module isdn_slot_port_tb_top;
    localparam int FR_CYC = 40;
    localparam int NVEC   = 8;
    // {strap, chan, tx, rx}
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 8'hA5, 8'h3C},
        {1'b0, 1'b1, 8'h81, 8'hE7},
        {1'b1, 1'b0, 8'h5A, 8'hC3},
        {1'b1, 1'b1, 8'hF0, 8'h0F},
        {1'b1, 1'b0, 8'h01, 8'h80},
        {1'b0, 1'b1, 8'hFF, 8'h00},
        {1'b0, 1'b0, 8'h00, 8'hFF},
        {1'b1, 1'b1, 8'h96, 8'h69}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic dclk = 1'b0, fsync = 1'b0, sdi = 1'b0, fmt_strap = 1'b0, chan_sel = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic sdo, sdo_oe, rx_valid;
    logic [7:0] rx_byte;

    int n_checks = 0, n_err = 0, rxv_total = 0;
    bit done = 0;
    bit have_cand = 0, m_cand = 0, m_ok = 0, m_fmt = 0;
    int m_run = 0;

    always #5 clk = ~clk;

    isdn_slot_port dut_i (
        .clk(clk), .rst(rst), .dclk(dclk), .fsync(fsync), .sdi(sdi),
        .fmt_strap(fmt_strap), .chan_sel(chan_sel), .tx_byte(tx_byte),
        .sdo(sdo), .sdo_oe(sdo_oe), .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    always @(posedge clk) if (rx_valid) rxv_total <= rxv_total + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    task automatic run_frame(input bit strap, input bit ch,
                             input logic [7:0] txb, input logic [7:0] rxb);
        int base, mm, rx0;
        logic [1:0] fa, fe;
        bit in_h, in_l, bitv;
        fmt_strap = strap;
        chan_sel  = ch;
        tx_byte   = txb;
        if (have_cand && strap == m_cand) m_run++;
        else m_run = 1;
        have_cand = 1;
        m_cand = strap;
        if (m_run >= 2) begin m_ok = 1; m_fmt = strap; end
        base = m_fmt ? (ch ? 10 : 0) : (ch ? 16 : 0);
        mm = 0; fa = 0; fe = 0;
        rx0 = rxv_total;
        for (int n = 0; n < FR_CYC; n++) begin
            fsync = (n == 0);
            @(negedge clk);
            dclk = 1'b1;
            @(negedge clk);
            if (!m_fmt) begin
                in_h = (n >= base) && (n <= base + 15);
                bitv = in_h ? rxb[7 - ((n - base) >> 1)] : n[0];
            end else begin
                in_h = (n >= base + 1) && (n <= base + 8);
                bitv = in_h ? rxb[7 - (n - base - 1)] : n[0];
            end
            sdi = bitv;
            repeat (3) @(negedge clk);
            in_h = in_h && m_ok;
            if (sdo_oe !== in_h || (in_h && sdo !== (m_fmt ? txb[7 - (n - base - 1)]
                                                             : txb[7 - ((n - base) >> 1)]))) begin
                if (mm == 0) begin
                    fa = {sdo_oe, sdo};
                    fe = {in_h, in_h ? (m_fmt ? txb[7 - (n - base - 1)]
                                              : txb[7 - ((n - base) >> 1)]) : sdo};
                end
                mm++;
            end
            if (in_h) tx_byte = ~txb;
            @(negedge clk);
            dclk = 1'b0;
            repeat (4) @(negedge clk);
            in_l = m_ok && (m_fmt ? (n >= base + 1 && n <= base + 7)
                                  : (n >= base && n <= base + 14));
            if (sdo_oe !== in_l) begin
                if (mm == 0) begin fa = {sdo_oe, 1'b0}; fe = {in_l, 1'b0}; end
                mm++;
            end
            @(negedge clk);
        end
        tx_byte = txb;
        chk(mm == 0, m_fmt ? "R3 R4 R7 R9 R11" : "R3 R4 R5 R9 R11",
            "slot window/bits", {30'd0, fa}, {30'd0, fe});
        if (m_ok) begin
            chk(rxv_total - rx0 == 1, m_fmt ? "R8 R10" : "R6 R10", "rx strobes",
                rxv_total - rx0, 1);
            chk(rx_byte === rxb, m_fmt ? "R8 R10" : "R6 R10", "rx byte", rx_byte, rxb);
        end else begin
            chk(rxv_total - rx0 == 0, "R2", "no capture before accept", rxv_total - rx0, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sdo_oe === 1'b0 && rx_valid === 1'b0, "R1", "outputs in reset",
            {sdo_oe, rx_valid}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(sdo_oe === 1'b0, "R1", "oe after reset", sdo_oe, 0);
        chk(rx_byte === 8'h00, "R1", "rx_byte after reset", rx_byte, 0);
        // first frame: strap seen once only, nothing should happen (R2)
        run_frame(1'b0, 1'b0, 8'h77, 8'h11);
        chk(sdo_oe === 1'b0, "R2", "oe idle after lone frame", sdo_oe, 0);
        for (int v = 0; v < NVEC; v++) begin
            run_frame(VEC[v][17], VEC[v][16], VEC[v][15:8], VEC[v][7:0]);
            run_frame(VEC[v][17], VEC[v][16], VEC[v][15:8] ^ 8'h3C, VEC[v][7:0] ^ 8'h42);
        end
        // strap toggling every frame must never switch format (R2)
        run_frame(1'b0, 1'b0, 8'hC6, 8'h5D);
        run_frame(1'b1, 1'b1, 8'h2B, 8'hB4);
        run_frame(1'b0, 1'b1, 8'hE1, 8'h1E);
        run_frame(1'b1, 1'b0, 8'h4D, 8'hD2);
        run_frame(1'b1, 1'b0, 8'h4D, 8'hD2);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule